// File: doc/BRIEF.md
# Triggered clock and frame-sync divider

This block divides a reference clock into an output clock and a frame-sync pulse train. Both outputs stay low until a trigger is seen. The trigger input is sampled on the falling edge of the reference clock. Once a trigger is accepted, the output clock starts after a fixed delay. The frame sync starts after a delay that its own divisor and a phase offset set. Every output edge is launched from a rising reference edge, so the outputs never change between reference edges.

The divisors, the phase and the pulse width are captured on the cycle that accepts the trigger. Later changes to these inputs are held back until the next accepted trigger. A trigger that arrives while the outputs are running has no effect. The `enable` input stops both outputs and re-arms the block for a new trigger.

Top module: `tcgd_top`

## Requirements
- R1: A trigger is accepted only if `trig_in` is high at a falling edge of `clk_ref` while `enable` is high and the block is idle. The acceptance takes effect at the next rising edge. A pulse that rises and falls between two falling edges is missed.
- R2: The first rising edge of `clk_out` is launched from the rising reference edge 2.5 reference periods after the falling edge that sampled the trigger. `clk_out` is low at the two rising edges before that one.
- R3: `clk_out` has a period of N reference periods, where N is the clock divisor. It is high for ceil(N/2) periods and then low for floor(N/2) periods. A divisor of 0 or 1 is treated as 2.
- R4: With frame-sync divisor D and phase P, the first rising edge of `fs_out` comes 2.5 + D − P reference periods after the falling edge that sampled the trigger.
- R5: After its first rising edge, `fs_out` rises every D reference periods. A frame-sync divisor of 0 is treated as 1.
- R6: A phase larger than the frame-sync divisor is treated as equal to it. The frame sync then starts together with the output clock.
- R7: `fs_out` stays high for W reference periods in each frame. A width of 0 is treated as 1, and a width larger than D is treated as D.
- R8: During reset, and from reset until a trigger is accepted, `clk_out` and `fs_out` are low. Both outputs change only at rising edges of `clk_ref`.
- R9: At the first rising edge where `enable` is sampled low, both outputs go low. They stay low, and triggers have no effect, for as long as `enable` stays low.
- R10: While the outputs are running, new triggers are ignored and the output pattern continues unchanged.
- R11: The divisors, phase and width are captured when the trigger is accepted. Changes to them during a run do not alter the running output pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Start trigger, sampled on falling edges of `clk_ref` |
| enable | input | 1 | When low, outputs are held low and the block is re-armed |
| clk_div | input | CDIV_W | Output clock divisor in reference periods |
| fs_div | input | FSD_W | Frame-sync period in reference periods |
| fs_phase | input | FSD_W | Frame-sync phase, which shortens the frame-sync start delay |
| fs_width | input | FSD_W | Frame-sync high time in reference periods |
| clk_out | output | 1 | Divided output clock |
| fs_out | output | 1 | Frame-sync pulse train |

## Verification
The bench sweeps every clock divisor from 0 to 5 against every frame-sync divisor, phase and width in small ranges. This covers the clamped values 0, 1 and 2, a phase above the divisor, and a width of zero or above the divisor. In every run the bench changes the configuration and pulses the trigger again after the outputs have started. A design that re-triggered mid-run, or that read its configuration live, would shift or reshape the pattern. If the start delay were off by one edge, or the trigger were sampled on the rising edge, the first clock or frame edge would land one period early or late. A short trigger pulse that misses the falling edge must leave the outputs quiet. Dropping `enable` while the trigger is held high must force both outputs low.

// File: rtl/tcgd_pkg.sv
`timescale 1ns/1ps
// Shared counter type, lane states and configuration arithmetic.
package tcgd_pkg;
  // Internal counter width; top-level input widths must stay below this.
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {LANE_IDLE, LANE_WAIT, LANE_RUN} lane_st_e;

  // Output clock period is never shorter than two reference periods.
  function automatic cnt_t fix_clk_div(cnt_t n);
    return (n < cnt_t'(2)) ? cnt_t'(2) : n;
  endfunction

  // Frame period of zero behaves as one.
  function automatic cnt_t fix_fs_div(cnt_t n);
    return (n == '0) ? cnt_t'(1) : n;
  endfunction

  // Phase cannot exceed the frame period.
  function automatic cnt_t fix_phase(cnt_t p, cnt_t d);
    return (p > d) ? d : p;
  endfunction

  // Pulse width lies between one and the frame period.
  function automatic cnt_t fix_width(cnt_t w, cnt_t d);
    cnt_t r;
    if (w == '0)   r = cnt_t'(1);
    else if (w > d) r = d;
    else            r = w;
    return r;
  endfunction

  // High part of the output clock: ceil(n/2).
  function automatic cnt_t high_part(cnt_t n);
    return n - (n >> 1);
  endfunction

  // Rising edges spent waiting after acceptance before the frame lane runs.
  function automatic cnt_t fs_lead(cnt_t d, cnt_t p);
    return cnt_t'(1) + d - p;
  endfunction
endpackage

// File: rtl/tcgd_arm.sv
`timescale 1ns/1ps
// Falling-edge trigger sampler and run flag.
module tcgd_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic enable,
  output logic accept,
  output logic running
);
  logic trig_seen;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) trig_seen <= 1'b0;
    else        trig_seen <= trig;
  end

  assign accept = enable && !running && trig_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      running <= 1'b0;
    else if (!enable) running <= 1'b0;
    else if (accept)  running <= 1'b1;
  end
endmodule

// File: rtl/tcgd_lane.sv
`timescale 1ns/1ps
// One divided output: waits a number of rising edges after load,
// then repeats a pattern that is high for hi_len out of every period edges.
module tcgd_lane
  import tcgd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  cnt_t lead,
  input  cnt_t period,
  input  cnt_t hi_len,
  output logic lvl
);
  lane_st_e st;
  cnt_t     wait_q;
  cnt_t     ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LANE_IDLE;
      wait_q <= '0;
      ph_q   <= '0;
      lvl    <= 1'b0;
    end else if (clear) begin
      st     <= LANE_IDLE;
      wait_q <= '0;
      ph_q   <= '0;
      lvl    <= 1'b0;
    end else if (load) begin
      st     <= LANE_WAIT;
      wait_q <= lead;
      ph_q   <= '0;
      lvl    <= 1'b0;
    end else begin
      case (st)
        LANE_WAIT: begin
          wait_q <= wait_q - cnt_t'(1);
          if (wait_q <= cnt_t'(1)) st <= LANE_RUN;
        end
        LANE_RUN: begin
          lvl  <= (ph_q < hi_len);
          ph_q <= (ph_q >= period - cnt_t'(1)) ? '0 : ph_q + cnt_t'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcgd_top.sv
`timescale 1ns/1ps
// Triggered clock and frame-sync divider.
module tcgd_top
  import tcgd_pkg::*;
#(
  parameter int unsigned CDIV_W = 8,  // must be below CNT_W
  parameter int unsigned FSD_W  = 8   // must be below CNT_W
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              enable,
  input  logic [CDIV_W-1:0] clk_div,
  input  logic [FSD_W-1:0]  fs_div,
  input  logic [FSD_W-1:0]  fs_phase,
  input  logic [FSD_W-1:0]  fs_width,
  output logic              clk_out,
  output logic              fs_out
);
  logic accept;
  logic running;

  // Live, clamped view of the configuration inputs.
  cnt_t cd_now, fd_now, ph_now, w_now, lead_now;
  assign cd_now   = fix_clk_div(cnt_t'(clk_div));
  assign fd_now   = fix_fs_div(cnt_t'(fs_div));
  assign ph_now   = fix_phase(cnt_t'(fs_phase), fd_now);
  assign w_now    = fix_width(cnt_t'(fs_width), fd_now);
  assign lead_now = fs_lead(fd_now, ph_now);

  // Configuration held for the run.
  cnt_t cdiv_q, chi_q, fsd_q, fsw_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cdiv_q <= cnt_t'(2);
      chi_q  <= cnt_t'(1);
      fsd_q  <= cnt_t'(1);
      fsw_q  <= cnt_t'(1);
    end else if (accept) begin
      cdiv_q <= cd_now;
      chi_q  <= high_part(cd_now);
      fsd_q  <= fd_now;
      fsw_q  <= w_now;
    end
  end

  tcgd_arm u_arm (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .trig    (trig_in),
    .enable  (enable),
    .accept  (accept),
    .running (running)
  );

  tcgd_lane u_ck (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clear  (!enable),
    .load   (accept),
    .lead   (cnt_t'(1)),
    .period (cdiv_q),
    .hi_len (chi_q),
    .lvl    (clk_out)
  );

  tcgd_lane u_fs (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clear  (!enable),
    .load   (accept),
    .lead   (lead_now),
    .period (fsd_q),
    .hi_len (fsw_q),
    .lvl    (fs_out)
  );
endmodule

// File: rtl/tcgd_chk.sv
`timescale 1ns/1ps
// Temporal checks on the divider, attached through bind.
module tcgd_chk
  import tcgd_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic acc,
  input logic run,
  input logic ck,
  input logic fs,
  input cnt_t cdiv_q,
  input cnt_t fsd_q,
  input cnt_t fsw_q
);
  // R8: nothing toggles while no run is in progress
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!ck && !fs));

  // R9: enable sampled low forces both outputs low
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!ck && !fs));

  // R2: outputs quiet on the two edges after acceptance
  p_quiet_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc) || ($past(acc, 2) && $past(run))) |-> (!ck && !fs));

  // R2: clock is high after the third edge of an uninterrupted run
  p_first_ck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(run, 2) && $past(acc, 3)) |-> ck);

  // R11: captured configuration does not move during a run
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(cdiv_q) && $stable(fsd_q) && $stable(fsw_q)));
endmodule

bind tcgd_top tcgd_chk u_chk (
  .clk    (clk_ref),
  .rst_n  (rst_n),
  .en     (enable),
  .acc    (accept),
  .run    (running),
  .ck     (clk_out),
  .fs     (fs_out),
  .cdiv_q (cdiv_q),
  .fsd_q  (fsd_q),
  .fsw_q  (fsw_q)
);

// File: tb/tb_tcgd_top.sv
`timescale 1ns/1ps
module tb_tcgd_top;
  localparam int CW = 8;
  localparam int FW = 8;
  localparam int NS = 30;

  logic          clk_ref = 1'b0;
  logic          rst_n   = 1'b0;
  logic          trig_in = 1'b0;
  logic          enable  = 1'b0;
  logic [CW-1:0] clk_div  = '0;
  logic [FW-1:0] fs_div   = '0;
  logic [FW-1:0] fs_phase = '0;
  logic [FW-1:0] fs_width = '0;
  logic          clk_out, fs_out;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_ref = ~clk_ref;

  tcgd_top #(.CDIV_W(CW), .FSD_W(FW)) dut (
    .clk_ref (clk_ref), .rst_n (rst_n), .trig_in (trig_in), .enable (enable),
    .clk_div (clk_div), .fs_div (fs_div), .fs_phase (fs_phase), .fs_width (fs_width),
    .clk_out (clk_out), .fs_out (fs_out)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Expected clock after the j-th rising edge counted from acceptance (j=0).
  function automatic logic exp_ck(input int cd, input int j);
    int n = (cd < 2) ? 2 : cd;
    if (j < 2) return 1'b0;
    return ((j - 2) % n) < ((n + 1) / 2);
  endfunction

  function automatic logic exp_fs(input int fd, input int ph, input int w, input int j);
    int d  = (fd == 0) ? 1 : fd;
    int p  = (ph > d) ? d : ph;
    int wc = (w == 0) ? 1 : ((w > d) ? d : w);
    int s  = 2 + d - p;
    if (j < s) return 1'b0;
    return ((j - s) % d) < wc;
  endfunction

  task automatic run(input int cd, input int fd, input int ph, input int w);
    string tc, tf;
    @(posedge clk_ref); #1;
    clk_div = CW'(cd); fs_div = FW'(fd); fs_phase = FW'(ph); fs_width = FW'(w);
    enable = 1'b1;
    @(posedge clk_ref); #1;
    chk("R8 idle clk", clk_out, 1'b0);
    chk("R8 idle fs", fs_out, 1'b0);
    trig_in = 1'b1;
    for (int j = 0; j < NS; j++) begin
      @(posedge clk_ref); #1;
      tc = (j < 7) ? "R2 R3 clk" : "R3 R10 R11 clk";
      tf = (j < 7) ? "R4 R5 R6 R7 fs" : "R5 R7 R10 R11 fs";
      chk(tc, clk_out, exp_ck(cd, j));
      chk(tf, fs_out, exp_fs(fd, ph, w, j));
      if (j == 6) begin
        // R11: new values must not reach the running pattern
        clk_div  = CW'((cd + 3) % 6);
        fs_div   = FW'((fd + 2) % 5);
        fs_phase = FW'((ph + 1) % 6);
        fs_width = FW'((w + 4) % 6);
        trig_in  = 1'b0;
      end
      if (j == 8) trig_in = 1'b1; // R10: retrigger while running
    end
    trig_in = 1'b0;
    @(posedge clk_ref); #1;
    enable  = 1'b0;
    trig_in = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_ref); #1;
      chk("R9 off clk", clk_out, 1'b0);
      chk("R9 off fs", fs_out, 1'b0);
    end
    trig_in = 1'b0;
    @(posedge clk_ref); #1;
  endtask

  initial begin
    #1;
    chk("R8 reset clk", clk_out, 1'b0);
    chk("R8 reset fs", fs_out, 1'b0);
    repeat (3) @(posedge clk_ref);
    #1;
    rst_n = 1'b1;
    clk_div = CW'(4); fs_div = FW'(3); fs_phase = '0; fs_width = FW'(1);
    enable = 1'b1;

    // R1: pulse entirely between two falling edges is missed
    @(posedge clk_ref); #0.5;
    trig_in = 1'b1;
    #1.5;
    trig_in = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_ref); #1;
      chk("R1 missed pulse clk", clk_out, 1'b0);
      chk("R1 missed pulse fs", fs_out, 1'b0);
    end

    // R1: trigger raised just before a falling edge is taken there
    @(posedge clk_ref); #2;
    trig_in = 1'b1;
    @(posedge clk_ref); #1;
    chk("R1 R2 edge0", clk_out, 1'b0);
    @(posedge clk_ref); #1;
    chk("R1 R2 edge1", clk_out, 1'b0);
    @(posedge clk_ref); #1;
    chk("R1 R2 edge2", clk_out, 1'b1);
    trig_in = 1'b0;
    enable  = 1'b0;
    repeat (2) @(posedge clk_ref);
    #1;

    for (int cd = 0; cd < 6; cd++)
      for (int fd = 0; fd < 5; fd++)
        for (int ph = 0; ph < 6; ph++)
          for (int w = 0; w < 6; w++)
            run(cd, fd, ph, w);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    total++;
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule